// File: doc/BRIEF.md
# Stack and interrupt vector sequencer

This block is the part of an 8-bit processor core that owns the program counter, the stack pointer and the status byte. It runs the multi-cycle memory sequences of stack traffic and control transfer: pushing and pulling single bytes, pushing and pulling the status byte, calling and returning from subroutines, returning from an interrupt, and entering a handler through software break, a maskable request line, an edge-sensitive non-maskable line, or reset. Opcode decode and arithmetic are outside the block. The decoder hands it a three-bit request code, a data byte and a call target. The block then drives a byte-wide synchronous memory port and returns the updated registers.

The stack pointer is eight bits wide and is always combined with a fixed page number, so stack traffic stays within one 256-byte page. The stack is full-descending. A push writes at the pointer and then decrements it. A pull increments the pointer and then reads. Handler entry pushes a return address, high byte first, and then a status byte. It then fetches a little-endian 16-bit vector from a fixed location near the top of memory.

Top module: `stack_irq_seq`

## Requirements
- R1: After rst_n is released, busy stays high for 6 cycles and no memory write occurs. The PC is then loaded with the word at FFFCh (low byte) and FFFDh (high byte), the stack pointer is FFh, and the status reads 24h.
- R2: Every stack access uses address {01h, sp}. A push writes at sp and then decrements it. A pull increments sp and then reads. sp wraps between 00h and FFh without leaving page 01h.
- R3: The req_op codes are 0 push byte, 1 push status, 2 pull byte, 3 pull status, 4 call, 5 return from subroutine, 6 return from interrupt and 7 break. They take 3, 3, 4, 4, 6, 6, 6 and 7 cycles: busy is high for that count minus one after the accepting edge.
- R4: Status bits are N=7, V=6, D=3, I=2, Z=1 and C=0. Bit 5 always reads 1 and bit 4 always reads 0. A status push or a break pushes the byte with bits 5 and 4 set. A status pull keeps bits 7, 6 and 3..0 of the pulled byte.
- R5: A call pushes PC+2, high byte then low byte, and loads PC with req_target. A return from subroutine pulls the low byte, then the high byte, and loads PC with that value plus 1.
- R6: A break pushes PC+2, then the status with bit 4 set. It sets I and loads PC from FFFEh/FFFFh.
- R7: A return from interrupt pulls the status first, then the PC low byte, then the PC high byte, and loads PC without adding 1.
- R8: irq is level-sensitive and is taken only while idle with I=0. Entry takes 7 cycles, pushes the current PC and the status with bit 4 clear, sets I and loads PC from FFFEh/FFFFh. While I=1, irq has no effect.
- R9: A rising edge on nmi is latched, even while busy, and is taken regardless of I. Entry pushes the PC and the status with bit 4 clear and loads PC from FFFAh/FFFBh. Holding nmi high does not start a second entry.
- R10: When the block is idle, a latched NMI wins over irq, and irq wins over a request. req_ready is low whenever an interrupt is about to be taken, and a request that is held is accepted after that interrupt entry completes.
- R11: A byte pull places the pulled byte on pull_data, which holds it until the next byte pull.
- R12: Read data is expected on mem_rdata in the cycle after mem_re. mem_we and mem_re are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; its release starts the reset-vector fetch |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Request code (see R3) |
| req_data | input | 8 | Byte for a push-byte request |
| req_target | input | 16 | Target address for a call |
| req_ready | output | 1 | High when a request would be accepted at this edge |
| irq | input | 1 | Maskable interrupt request, level |
| nmi | input | 1 | Non-maskable interrupt, rising edge |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after mem_re |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer (low byte of the page-01h address) |
| status | output | 8 | Status byte |
| pull_data | output | 8 | Last byte returned by a byte pull |
| busy | output | 1 | A sequence is in progress |

## Verification
Two kinds of collision can happen while the block is idle. A pending NMI or an active irq can meet a request that is already presented in the same cycle. The bench latches an NMI edge while a push is still running and keeps a second push waiting. It expects req_ready to be low in the first idle cycle, the NMI entry to run before the push, and the push to complete afterwards with its byte below the NMI frame. It also raises irq with I cleared in the same cycle that a push is offered, and checks that the push is deferred and lands after the interrupt frame.

// File: rtl/stack_irq_pkg.sv
package stack_irq_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int STEP_W = 3;

    // status bit positions
    localparam int ST_I   = 2;
    localparam int ST_BRK = 4;
    localparam int ST_ONE = 5;

    typedef enum logic [3:0] {
        OP_PSH  = 4'd0,
        OP_PSHS = 4'd1,
        OP_PUL  = 4'd2,
        OP_PULS = 4'd3,
        OP_CALL = 4'd4,
        OP_RSUB = 4'd5,
        OP_RINT = 4'd6,
        OP_BRK  = 4'd7,
        OP_IRQ  = 4'd8,
        OP_NMI  = 4'd9,
        OP_RST  = 4'd10
    } op_e;

    typedef struct packed {
        logic                busy;
        op_e                 op;
        logic [STEP_W-1:0]   step;
        logic [ADDR_W-1:0]   pc;
        logic [DATA_W-1:0]   sp;
        logic [DATA_W-1:0]   st;
        logic [DATA_W-1:0]   lo;
        logic [DATA_W-1:0]   wbyte;
        logic [ADDR_W-1:0]   tgt;
        logic [DATA_W-1:0]   pull;
    } seq_t;

    typedef struct packed {
        logic nmi_prev;
        logic nmi_pend;
    } arb_t;

    // last busy step of each sequence (total cycles minus one)
    function automatic logic [STEP_W-1:0] last_step(op_e op);
        case (op)
            OP_PSH, OP_PSHS:          return 3'd2;
            OP_PUL, OP_PULS:          return 3'd3;
            OP_CALL, OP_RSUB, OP_RINT: return 3'd5;
            default:                  return 3'd6;
        endcase
    endfunction

    // bring a byte taken from the stack into register form
    function automatic logic [DATA_W-1:0] fix_status(logic [DATA_W-1:0] b);
        logic [DATA_W-1:0] r;
        r         = b;
        r[ST_ONE] = 1'b1;
        r[ST_BRK] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/stack_irq_vec.sv
module stack_irq_vec
    import stack_irq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] VEC_NMI = 16'hFFFA,
    parameter logic [ADDR_W-1:0] VEC_RST = 16'hFFFC,
    parameter logic [ADDR_W-1:0] VEC_IRQ = 16'hFFFE
) (
    input  op_e               op,
    input  logic              hi_sel,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] base;

    always_comb begin
        case (op)
            OP_NMI:  base = VEC_NMI;
            OP_RST:  base = VEC_RST;
            default: base = VEC_IRQ;
        endcase
        addr = base + {{(ADDR_W-1){1'b0}}, hi_sel};
    end

endmodule

// File: rtl/stack_irq_arb.sv
module stack_irq_arb
    import stack_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nmi,
    input  logic irq,
    input  logic i_mask,
    input  logic idle,
    output logic nmi_take,
    output logic irq_take
);

    arb_t arb_d, arb_q;

    always_comb begin
        nmi_take       = idle & arb_q.nmi_pend;
        irq_take       = idle & ~arb_q.nmi_pend & irq & ~i_mask;
        arb_d.nmi_prev = nmi;
        arb_d.nmi_pend = (nmi & ~arb_q.nmi_prev) | (arb_q.nmi_pend & ~nmi_take);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arb_q <= '{nmi_prev: 1'b1, nmi_pend: 1'b0};
        end else begin
            arb_q <= arb_d;
        end
    end

endmodule

// File: rtl/stack_irq_seq.sv
module stack_irq_seq
    import stack_irq_pkg::*;
#(
    parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
    parameter logic [ADDR_W-1:0] VEC_NMI    = 16'hFFFA,
    parameter logic [ADDR_W-1:0] VEC_RST    = 16'hFFFC,
    parameter logic [ADDR_W-1:0] VEC_IRQ    = 16'hFFFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [DATA_W-1:0] req_data,
    input  logic [ADDR_W-1:0] req_target,
    output logic              req_ready,
    input  logic              irq,
    input  logic              nmi,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] sp,
    output logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] pull_data,
    output logic              busy
);

    localparam logic [DATA_W-1:0] ST_RESET = 8'h24;
    localparam logic [DATA_W-1:0] ONE_BIT  = 8'h20;
    localparam logic [DATA_W-1:0] BRK_BITS = 8'h30;

    seq_t seq_d, seq_q;

    logic              nmi_take;
    logic              irq_take;
    logic              use_vec;
    logic              vec_hi;
    logic [ADDR_W-1:0] vec_addr;
    logic [ADDR_W-1:0] stk_addr;
    logic [ADDR_W-1:0] ret_addr;

    stack_irq_arb u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi      (nmi),
        .irq      (irq),
        .i_mask   (seq_q.st[ST_I]),
        .idle     (~seq_q.busy),
        .nmi_take (nmi_take),
        .irq_take (irq_take)
    );

    stack_irq_vec #(
        .VEC_NMI (VEC_NMI),
        .VEC_RST (VEC_RST),
        .VEC_IRQ (VEC_IRQ)
    ) u_vec (
        .op     (seq_q.op),
        .hi_sel (vec_hi),
        .addr   (vec_addr)
    );

    always_comb begin
        seq_d     = seq_q;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_wdata = '0;
        use_vec   = 1'b0;
        vec_hi    = 1'b0;
        stk_addr  = {STACK_PAGE, seq_q.sp};
        ret_addr  = (seq_q.op == OP_CALL || seq_q.op == OP_BRK) ? seq_q.pc + 16'd2 : seq_q.pc;

        if (!seq_q.busy) begin
            if (nmi_take) begin
                seq_d.busy = 1'b1;
                seq_d.op   = OP_NMI;
                seq_d.step = 3'd1;
            end else if (irq_take) begin
                seq_d.busy = 1'b1;
                seq_d.op   = OP_IRQ;
                seq_d.step = 3'd1;
            end else if (req_valid) begin
                seq_d.busy  = 1'b1;
                seq_d.op    = op_e'({1'b0, req_op});
                seq_d.step  = 3'd1;
                seq_d.wbyte = req_data;
                seq_d.tgt   = req_target;
            end
        end else begin
            seq_d.step = seq_q.step + 3'd1;
            if (seq_q.step == last_step(seq_q.op)) begin
                seq_d.busy = 1'b0;
                seq_d.step = '0;
            end

            case (seq_q.op)
                OP_PSH, OP_PSHS: begin
                    if (seq_q.step == 3'd1) begin
                        mem_we    = 1'b1;
                        mem_wdata = (seq_q.op == OP_PSH) ? seq_q.wbyte : (seq_q.st | BRK_BITS);
                        seq_d.sp  = seq_q.sp - 8'd1;
                    end
                end

                OP_PUL, OP_PULS: begin
                    case (seq_q.step)
                        3'd1: seq_d.sp = seq_q.sp + 8'd1;
                        3'd2: mem_re = 1'b1;
                        3'd3: begin
                            if (seq_q.op == OP_PUL) seq_d.pull = mem_rdata;
                            else                    seq_d.st   = fix_status(mem_rdata);
                        end
                        default: ;
                    endcase
                end

                OP_CALL: begin
                    case (seq_q.step)
                        3'd2: begin
                            mem_we    = 1'b1;
                            mem_wdata = ret_addr[15:8];
                            seq_d.sp  = seq_q.sp - 8'd1;
                        end
                        3'd3: begin
                            mem_we    = 1'b1;
                            mem_wdata = ret_addr[7:0];
                            seq_d.sp  = seq_q.sp - 8'd1;
                        end
                        3'd5: seq_d.pc = seq_q.tgt;
                        default: ;
                    endcase
                end

                OP_RSUB: begin
                    case (seq_q.step)
                        3'd1: seq_d.sp = seq_q.sp + 8'd1;
                        3'd2: begin
                            mem_re   = 1'b1;
                            seq_d.sp = seq_q.sp + 8'd1;
                        end
                        3'd3: begin
                            seq_d.lo = mem_rdata;
                            mem_re   = 1'b1;
                        end
                        3'd4: seq_d.pc = {mem_rdata, seq_q.lo} + 16'd1;
                        default: ;
                    endcase
                end

                OP_RINT: begin
                    case (seq_q.step)
                        3'd1: seq_d.sp = seq_q.sp + 8'd1;
                        3'd2: begin
                            mem_re   = 1'b1;
                            seq_d.sp = seq_q.sp + 8'd1;
                        end
                        3'd3: begin
                            seq_d.st = fix_status(mem_rdata);
                            mem_re   = 1'b1;
                            seq_d.sp = seq_q.sp + 8'd1;
                        end
                        3'd4: begin
                            seq_d.lo = mem_rdata;
                            mem_re   = 1'b1;
                        end
                        3'd5: seq_d.pc = {mem_rdata, seq_q.lo};
                        default: ;
                    endcase
                end

                default: begin
                    // break, maskable, non-maskable and reset entry
                    case (seq_q.step)
                        3'd1: begin
                            if (seq_q.op != OP_RST) begin
                                mem_we    = 1'b1;
                                mem_wdata = ret_addr[15:8];
                                seq_d.sp  = seq_q.sp - 8'd1;
                            end
                        end
                        3'd2: begin
                            if (seq_q.op != OP_RST) begin
                                mem_we    = 1'b1;
                                mem_wdata = ret_addr[7:0];
                                seq_d.sp  = seq_q.sp - 8'd1;
                            end
                        end
                        3'd3: begin
                            if (seq_q.op != OP_RST) begin
                                mem_we    = 1'b1;
                                mem_wdata = seq_q.st | ((seq_q.op == OP_BRK) ? BRK_BITS : ONE_BIT);
                                seq_d.sp  = seq_q.sp - 8'd1;
                            end
                            seq_d.st[ST_I] = 1'b1;
                        end
                        3'd4: begin
                            use_vec = 1'b1;
                            mem_re  = 1'b1;
                        end
                        3'd5: begin
                            seq_d.lo = mem_rdata;
                            use_vec  = 1'b1;
                            vec_hi   = 1'b1;
                            mem_re   = 1'b1;
                        end
                        3'd6: seq_d.pc = {mem_rdata, seq_q.lo};
                        default: ;
                    endcase
                end
            endcase
        end

        mem_addr = use_vec ? vec_addr : stk_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{busy: 1'b1, op: OP_RST, step: 3'd1, pc: '0, sp: 8'hFF,
                       st: ST_RESET, lo: '0, wbyte: '0, tgt: '0, pull: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready = ~seq_q.busy & ~nmi_take & ~irq_take;
    assign pc        = seq_q.pc;
    assign sp        = seq_q.sp;
    assign status    = seq_q.st;
    assign pull_data = seq_q.pull;
    assign busy      = seq_q.busy;

endmodule

// File: rtl/stack_irq_chk.sv
module stack_irq_chk #(
    parameter logic [7:0] PAGE = 8'h01
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_we,
    input logic        mem_re,
    input logic [15:0] mem_addr,
    input logic [7:0]  sp,
    input logic [7:0]  status,
    input logic        busy,
    input logic        req_ready
);

    assert_wr_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr == {PAGE, sp});

    assert_sp_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sp == $past(sp) - 8'd1);

    assert_st_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        status[5] && !status[4]);

    assert_no_rw_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !busy);

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we && !mem_re);

endmodule

bind stack_irq_seq stack_irq_chk #(.PAGE(STACK_PAGE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .sp        (sp),
    .status    (status),
    .busy      (busy),
    .req_ready (req_ready)
);

// File: tb/stack_irq_seq_test.sv
module stack_irq_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [7:0]  req_data = '0;
    logic [15:0] req_target = '0;
    logic        req_ready;
    logic        irq = 1'b0;
    logic        nmi = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_we;
    logic        mem_re;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic [15:0] pc;
    logic [7:0]  sp;
    logic [7:0]  status;
    logic [7:0]  pull_data;
    logic        busy;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    stack_irq_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_data(req_data), .req_target(req_target), .req_ready(req_ready),
        .irq(irq), .nmi(nmi), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .pc(pc), .sp(sp), .status(status), .pull_data(pull_data), .busy(busy)
    );

    // synchronous memory: stack page plus the six vector bytes
    logic [7:0] stk  [256];
    logic [7:0] vtab [6];
    logic [7:0] rd_q;
    logic       wr_seen;

    function automatic logic [7:0] rd_byte(logic [15:0] a);
        if (a[15:8] == 8'h01)  return stk[a[7:0]];
        if (a >= 16'hFFFA)     return vtab[3'(a - 16'hFFFA)];
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) stk[i] <= 8'h00;
            rd_q    <= 8'h00;
            wr_seen <= 1'b0;
        end else begin
            if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
            if (mem_we) wr_seen <= 1'b1;
            if (mem_re) rd_q <= rd_byte(mem_addr);
        end
    end
    assign mem_rdata = rd_q;

    // reference state
    logic [15:0] ref_pc;
    logic [7:0]  ref_sp;
    logic [7:0]  ref_st;
    logic [7:0]  ref_pull;
    logic [7:0]  ref_stk [256];

    localparam logic [15:0] V_RST = 16'hC000;
    localparam logic [15:0] V_NMI = 16'hA55A;
    localparam logic [15:0] V_IRQ = 16'h8EF1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rpush(input logic [7:0] b);
        ref_stk[ref_sp] = b;
        ref_sp = ref_sp - 8'd1;
    endtask

    function automatic logic [7:0] rpull();
        ref_sp = ref_sp + 8'd1;
        return ref_stk[ref_sp];
    endfunction

    // expected effect of one sequence; n = expected busy cycles
    task automatic model(input int code, input logic [7:0] d, input logic [15:0] t, output int n);
        logic [15:0] r;
        logic [7:0]  lo, hi;
        case (code)
            0: begin rpush(d); n = 2; end
            1: begin rpush(ref_st | 8'h30); n = 2; end
            2: begin ref_pull = rpull(); n = 3; end
            3: begin ref_st = (rpull() & 8'hCF) | 8'h20; n = 3; end
            4: begin
                r = ref_pc + 16'd2; rpush(r[15:8]); rpush(r[7:0]); ref_pc = t; n = 5;
            end
            5: begin
                lo = rpull(); hi = rpull(); ref_pc = {hi, lo} + 16'd1; n = 5;
            end
            6: begin
                ref_st = (rpull() & 8'hCF) | 8'h20;
                lo = rpull(); hi = rpull(); ref_pc = {hi, lo}; n = 5;
            end
            default: begin
                r = (code == 7) ? ref_pc + 16'd2 : ref_pc;
                rpush(r[15:8]); rpush(r[7:0]);
                rpush(ref_st | ((code == 7) ? 8'h30 : 8'h20));
                ref_st = ref_st | 8'h04;
                ref_pc = (code == 9) ? V_NMI : V_IRQ;
                n = 6;
            end
        endcase
    endtask

    task automatic check_state(input string tag);
        int mism = 0;
        chk({tag, " pc"}, pc, ref_pc);
        chk({tag, " sp"}, sp, ref_sp);
        chk({tag, " status"}, status, ref_st);
        for (int i = 0; i < 256; i++) if (stk[i] !== ref_stk[i]) mism++;
        chk({tag, " stack mismatches"}, mism, 0);
    endtask

    task automatic run_req(input int code, input logic [7:0] d, input logic [15:0] t, input string tag);
        int n = 0;
        int en;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = 3'(code); req_data = d; req_target = t;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) begin n++; @(negedge clk); end
        model(code, d, t, en);
        chk({tag, " R3 cycles"}, n, en);
        check_state(tag);
        if (code == 2) chk("R11 pull_data", pull_data, ref_pull);
    endtask

    task automatic count_int(input int code, input string tag);
        int n = 0;
        int en;
        while (!busy) @(negedge clk);
        while (busy) begin n++; @(negedge clk); end
        model(code, 8'h00, 16'h0000, en);
        chk({tag, " entry cycles"}, n, en);
        check_state(tag);
    endtask

    initial begin
        int en;
        int n;
        logic [15:0] saved;
        int unused_seed;
        unused_seed = $urandom(32'h5eed);
        vtab[0] = V_NMI[7:0]; vtab[1] = V_NMI[15:8];
        vtab[2] = V_RST[7:0]; vtab[3] = V_RST[15:8];
        vtab[4] = V_IRQ[7:0]; vtab[5] = V_IRQ[15:8];
        for (int i = 0; i < 256; i++) ref_stk[i] = 8'h00;
        ref_pc = V_RST; ref_sp = 8'hFF; ref_st = 8'h24; ref_pull = 8'h00;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        chk("R1 reset busy cycles", n, 6);
        chk("R1 no write during reset", wr_seen, 0);
        check_state("R1 reset");
        chk("R10 ready after reset", req_ready, 1);

        // call / return round trip
        saved = ref_pc;
        run_req(4, 8'h00, 16'h4321, "R5 call");
        run_req(5, 8'h00, 16'h0000, "R5 return");
        chk("R5 return pc", pc, saved + 16'd3);

        // byte push / pull
        run_req(0, 8'hC3, 16'h0, "R2 push");
        run_req(2, 8'h00, 16'h0, "R11 pull");
        chk("R11 pulled byte", pull_data, 8'hC3);

        // status push / pull
        run_req(1, 8'h00, 16'h0, "R4 push status");
        chk("R4 pushed status", stk[ref_sp + 8'd1], 8'h34);
        run_req(0, 8'hFF, 16'h0, "R4 push ones");
        run_req(3, 8'h00, 16'h0, "R4 pull status");
        chk("R4 pulled status", status, 8'hEF);

        // break then return from interrupt
        saved = ref_pc;
        run_req(7, 8'h00, 16'h0, "R6 break");
        chk("R6 pushed bit4", stk[ref_sp + 8'd1][4], 1);
        chk("R6 vector", pc, V_IRQ);
        run_req(6, 8'h00, 16'h0, "R7 return int");
        chk("R7 pc", pc, saved + 16'd2);

        // masked irq: I=1 after pushing/pulling a byte with I set
        run_req(0, 8'h04, 16'h0, "R8 prep");
        run_req(3, 8'h00, 16'h0, "R8 set I");
        @(negedge clk);
        irq = 1'b1;
        repeat (5) @(negedge clk);
        chk("R8 masked irq busy", busy, 0);
        chk("R8 masked irq ready", req_ready, 1);
        chk("R8 masked irq pc", pc, ref_pc);
        run_req(0, 8'h5C, 16'h0, "R8 push while masked");
        irq = 1'b0;

        // irq taken with I=0
        run_req(0, 8'h00, 16'h0, "R8 prep clr");
        run_req(3, 8'h00, 16'h0, "R8 clear I");
        @(negedge clk);
        irq = 1'b1;
        @(negedge clk);
        count_int(8, "R8 irq");
        irq = 1'b0;
        chk("R8 pushed bit4 clear", stk[ref_sp + 8'd1][4], 0);
        chk("R8 I set", status[2], 1);

        // nmi with I=1, held high afterwards
        @(negedge clk);
        nmi = 1'b1;
        count_int(9, "R9 nmi");
        chk("R9 vector", pc, V_NMI);
        repeat (8) @(negedge clk);
        chk("R9 no retrigger", busy, 0);
        nmi = 1'b0;

        // collision: nmi latched during a push, second push waiting
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = 3'd0; req_data = 8'h11;
        @(negedge clk);
        nmi = 1'b1; req_data = 8'h77;
        while (busy) @(negedge clk);
        model(0, 8'h11, 16'h0, en);
        chk("R10 nmi beats request ready", req_ready, 0);
        @(negedge clk);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        model(9, 8'h00, 16'h0, en);
        chk("R10 nmi entry cycles", n, en);
        chk("R10 nmi pc", pc, V_NMI);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        model(0, 8'h77, 16'h0, en);
        chk("R10 deferred push cycles", n, en);
        check_state("R10 nmi collision");
        nmi = 1'b0;

        // collision: irq and request in the same cycle
        run_req(0, 8'h00, 16'h0, "R10 prep");
        run_req(3, 8'h00, 16'h0, "R10 clear I");
        @(negedge clk);
        irq = 1'b1; req_valid = 1'b1; req_op = 3'd0; req_data = 8'h5A;
        #1;
        chk("R10 irq beats request", req_ready, 0);
        @(negedge clk);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        model(8, 8'h00, 16'h0, en);
        chk("R10 irq entry cycles", n, en);
        irq = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        model(0, 8'h5A, 16'h0, en);
        chk("R10 deferred push after irq", n, en);
        check_state("R10 irq collision");

        // stack pointer wraps within page 1
        for (int i = 0; i < 260; i++) run_req(0, 8'(i), 16'h0, "R2 wrap push");
        for (int i = 0; i < 6; i++) run_req(2, 8'h00, 16'h0, "R2 wrap pull");

        // constrained random mix
        for (int i = 0; i < 80; i++) begin
            run_req(int'($urandom_range(0, 7)), 8'($urandom), 16'($urandom), "R3 random");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R3 actual=hung expected=complete");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule